// File: doc/BRIEF.md
# EEPROM Page Load Buffer

This block models the memory-side write logic of a byte-wide parallel EEPROM. A host writes bytes one strobe at a time into a page latch. After the last byte, and once no new byte has come for a fixed window, the block writes the whole page into its backing array in one programming phase of fixed length. The host sees the device as busy only while that phase runs.

The low address bits pick the byte inside the page, and the upper bits pick the page. The first byte of a load fixes the page. A byte aimed at a different page during the same load is refused and flagged. Each refused strobe, and each strobe that arrives during programming, leaves the latch and the array unchanged. Reads return the array contents, so new data becomes visible only after the commit. All times are counted in clock cycles derived from a clock rate parameter given in MHz.

Top module: `eeprom_page_buffer`

## Requirements
- R1: After reset `busy` and `protoErr` are low and every array location reads FFh (the erased value).
- R2: A byte write completes on the clock edge where `weN` is first seen high after being low while `csN` is low. The byte offset is `addr[6:0]` and the page number is the bits of `addr` above bit 6.
- R3: The first accepted byte of a load fixes the page. A later strobe in that load with a different page number is not latched and does not restart the timeout, and `protoErr` is high for exactly the one cycle after that edge.
- R4: Every accepted byte restarts the load timeout of LOAD_CYC = CLK_MHZ*LOAD_US cycles. `busy` rises exactly LOAD_CYC clock edges after the last accepted byte edge. A byte that arrives one cycle before expiry extends the load.
- R5: `busy` stays high for exactly PROG_CYC = CLK_MHZ*PROG_US cycles, whether 1 or 128 bytes were loaded.
- R6: At commit only the page locations loaded in that load change, and the other locations keep their contents. When one offset is written twice in a load, the later value is stored.
- R7: While a load is pending and while `busy` is high, reads return the old array contents. The new contents can be read from the cycle after `busy` falls.
- R8: Write strobes while `busy` is high change no latch or array content and do not start a new load. `busy` stays low after the commit.
- R9: `rdData` equals the array byte at `addr` when `csN` and `oeN` are both low, and is 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write strobe; byte taken on its rising edge |
| oeN | input | 1 | Active-low output enable for reads |
| addr | input | ADDR_W | Byte address: offset in low 7 bits, page above |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data from the backing array |
| busy | output | 1 | High during the programming phase |
| protoErr | output | 1 | One-cycle pulse on a refused cross-page byte |

## Verification
The bench loads a full 128-byte page with a computed data ramp. It then makes a sparse load with a repeated offset, and a single-byte load. These show whether the valid mask limits the commit to loaded bytes and whether the programming time depends on the byte count. Strobe gaps of three cycles and of one cycle short of expiry show whether the timeout restarts. A cross-page strobe shows whether it is refused without extending the timeout. Strobes and reads issued during the load and the programming phase show whether the array stays unchanged until the commit. Full-array read sweeps against an arithmetic model catch stray writes anywhere.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capPage;   // fix page number of a new load
    logic loadByte;  // write current byte into the page latch
    logic commit;    // copy valid latch bytes into the array
  } pgCtl_t;

endpackage

// File: rtl/eepg_ctrl.sv
module eepg_ctrl
  import eepg_pkg::*;
#(
  parameter int LOAD_CYC = 150,
  parameter int PROG_CYC = 6000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   weN,
  input  logic   pageMatch,
  output pgCtl_t ctl,
  output logic   busy,
  output logic   protoErr
);

  localparam int LW = $clog2(LOAD_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam logic [LW-1:0] LOAD_TOP = LW'(LOAD_CYC - 1);
  localparam logic [PW-1:0] PROG_TOP = PW'(PROG_CYC - 1);

  pgState_e stateQ;
  logic [LW-1:0] loadCnt;
  logic [PW-1:0] progCnt;
  logic weNPrev;
  logic wrDone;
  logic loadExpired;
  logic errNext;

  // a write completes when the strobe rises with the chip selected
  assign wrDone = !csN && weN && !weNPrev;
  assign loadExpired = (loadCnt == '0);

  always_comb begin
    ctl = '0;
    errNext = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (wrDone) begin
          ctl.capPage  = 1'b1;
          ctl.loadByte = 1'b1;
        end
      end
      ST_LOAD: begin
        if (!loadExpired && wrDone) begin
          if (pageMatch) ctl.loadByte = 1'b1;
          else           errNext      = 1'b1;
        end
      end
      ST_PROG: begin
        if (progCnt == '0) ctl.commit = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      loadCnt  <= '0;
      progCnt  <= '0;
      weNPrev  <= 1'b1;
      protoErr <= 1'b0;
    end else begin
      weNPrev  <= weN;
      protoErr <= errNext;
      unique case (stateQ)
        ST_IDLE: begin
          if (wrDone) begin
            stateQ  <= ST_LOAD;
            loadCnt <= LOAD_TOP;
          end
        end
        ST_LOAD: begin
          if (loadExpired) begin
            stateQ  <= ST_PROG;
            progCnt <= PROG_TOP;
          end else if (ctl.loadByte) begin
            loadCnt <= LOAD_TOP;
          end else begin
            loadCnt <= loadCnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (progCnt == '0) stateQ <= ST_IDLE;
          else               progCnt <= progCnt - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ == ST_PROG);

  AST_NO_LATCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(ctl.loadByte || ctl.capPage)); // R8

  AST_BUSY_ENDS_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(ctl.commit)); // R5

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (loadCnt <= LOAD_TOP) && (progCnt <= PROG_TOP)); // R4

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !busy); // R3

endmodule

// File: rtl/eepg_datapath.sv
module eepg_datapath
  import eepg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgCtl_t            ctl,
  input  logic              csN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic              pageMatch,
  output logic [7:0]        rdData
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PAGE_W-1:0]     pageQ;
  logic [7:0]            latchQ [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;
  logic [7:0]            mem    [DEPTH];
  logic [OFF_W-1:0]      offset;
  logic [PAGE_W-1:0]     pageIn;

  assign offset    = addr[OFF_W-1:0];
  assign pageIn    = addr[ADDR_W-1:OFF_W];
  assign pageMatch = (pageIn == pageQ);

  // page latch and per-byte valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ  <= '0;
      validQ <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) latchQ[i] <= 8'h00;
    end else begin
      if (ctl.capPage) pageQ <= pageIn;
      if (ctl.commit) begin
        validQ <= '0;
      end else if (ctl.loadByte) begin
        latchQ[offset] <= wrData;
        validQ[offset] <= 1'b1;
      end
    end
  end

  // backing array, written only on commit for valid bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (ctl.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (validQ[i]) mem[{pageQ, OFF_W'(i)}] <= latchQ[i];
      end
    end
  end

  assign rdData = (!csN && !oeN) ? mem[addr] : 8'h00;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((|validQ) && !ctl.commit) |=> $stable(pageQ)); // R3

  AST_LOAD_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadByte && (|validQ)) |-> pageMatch); // R3

  AST_NO_LOAD_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> !ctl.loadByte); // R8

endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer
  import eepg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 128,
  parameter int CLK_MHZ    = 1,
  parameter int LOAD_US    = 150,
  parameter int PROG_US    = 6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              protoErr
);

  localparam int LOAD_CYC = CLK_MHZ * LOAD_US;
  localparam int PROG_CYC = CLK_MHZ * PROG_US;

  pgCtl_t ctl;
  logic   pageMatch;

  eepg_ctrl #(
    .LOAD_CYC(LOAD_CYC),
    .PROG_CYC(PROG_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .weN      (weN),
    .pageMatch(pageMatch),
    .ctl      (ctl),
    .busy     (busy),
    .protoErr (protoErr)
  );

  eepg_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .csN      (csN),
    .oeN      (oeN),
    .addr     (addr),
    .wrData   (wrData),
    .pageMatch(pageMatch),
    .rdData   (rdData)
  );

endmodule

// File: tb/tb_eeprom_page_buffer.sv
module tb_eeprom_page_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 9;
  localparam int PB         = 128;
  localparam int LOAD_CYC   = 12;
  localparam int PROG_CYC   = 40;
  localparam int DEPTH      = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic busy, protoErr;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] pendD [PB];
  logic       pendV [PB];
  int         pendPage;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_buffer #(
    .ADDR_W(AW), .PAGE_BYTES(PB), .CLK_MHZ(1), .LOAD_US(LOAD_CYC), .PROG_US(PROG_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .busy(busy), .protoErr(protoErr)
  );

  task automatic chk(input int act, input int exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(input int page, input int off);
    return AW'(page * PB + off);
  endfunction

  // returns at the negedge just after the completing edge
  task automatic doStrobe(input int page, input int off, input logic [7:0] d);
    @(negedge clk); csN = 1'b0; weN = 1'b0; addr = mkAddr(page, off); wrData = d;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic noteByte(input int page, input int off, input logic [7:0] d);
    pendPage = page; pendD[off] = d; pendV[off] = 1'b1;
  endtask

  task automatic applyCommit();
    for (int i = 0; i < PB; i++) begin
      if (pendV[i]) model[pendPage * PB + i] = pendD[i];
      pendV[i] = 1'b0;
    end
  endtask

  task automatic readChk(input int page, input int off, input string req);
    @(negedge clk); csN = 1'b0; oeN = 1'b0; addr = mkAddr(page, off);
    #1 chk(int'(rdData), int'(model[page * PB + off]), req);
    csN = 1'b1; oeN = 1'b1;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) readChk(a / PB, a % PB, req);
  endtask

  task automatic waitRise(output int n);
    n = 0;
    while (!busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic waitFall(output int m);
    m = 0;
    while (busy && m < 1000) begin @(negedge clk); m++; end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int n, m;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    for (int i = 0; i < PB; i++) begin pendV[i] = 1'b0; pendD[i] = 8'h00; end
    pendPage = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(int'(busy), 0, "R1 busy after reset");
    chk(int'(protoErr), 0, "R1 protoErr after reset");
    sweep("R1 erased array");

    // R9 output disabled
    @(negedge clk); csN = 1'b0; oeN = 1'b1; addr = mkAddr(0, 0);
    #1 chk(int'(rdData), 0, "R9 oeN high gives zero");
    csN = 1'b1; oeN = 1'b0;
    #1 chk(int'(rdData), 0, "R9 csN high gives zero");
    oeN = 1'b1;

    // R2 R6 full page ramp on page 1
    for (int i = 0; i < PB; i++) begin
      doStrobe(1, i, 8'((i * 37 + 5) & 8'hFF));
      noteByte(1, i, 8'((i * 37 + 5) & 8'hFF));
    end
    waitRise(n);
    chk(n, LOAD_CYC, "R4 busy delay after full page");
    waitFall(m);
    chk(m, PROG_CYC, "R5 programming length full page");
    applyCommit();
    sweep("R2 R6 full page contents");

    // R6 R4 sparse load on page 2, repeated offset, late restart
    doStrobe(2, 0, 8'hA1);   noteByte(2, 0, 8'hA1);
    doStrobe(2, 5, 8'hB2);   noteByte(2, 5, 8'hB2);
    repeat (LOAD_CYC - 4) @(negedge clk);
    doStrobe(2, 5, 8'hC3);   noteByte(2, 5, 8'hC3);
    chk(int'(busy), 0, "R4 strobe one cycle before expiry extends load");
    repeat (LOAD_CYC - 4) @(negedge clk);
    doStrobe(2, 127, 8'hD4); noteByte(2, 127, 8'hD4);
    waitRise(n);
    chk(n, LOAD_CYC, "R4 busy delay after restarted load");
    waitFall(m);
    chk(m, PROG_CYC, "R5 programming length sparse load");
    applyCommit();
    sweep("R6 sparse load keeps other bytes");

    // R3 cross-page strobe refused
    doStrobe(3, 10, 8'h3C);  noteByte(3, 10, 8'h3C);
    doStrobe(0, 10, 8'h77);
    chk(int'(protoErr), 1, "R3 protoErr pulse on page mismatch");
    @(negedge clk);
    chk(int'(protoErr), 0, "R3 protoErr lasts one cycle");
    waitRise(n);
    chk(n, LOAD_CYC - 4, "R3 refused strobe does not restart timeout");
    waitFall(m);
    applyCommit();
    readChk(0, 10, "R3 refused byte not stored");
    readChk(3, 10, "R3 first page byte stored");

    // R7 R8 single byte, reads and strobes during load and busy
    doStrobe(0, 1, 8'h5A);
    readChk(0, 1, "R7 old data during load");
    noteByte(0, 1, 8'h5A);
    waitRise(n);
    chk(n, LOAD_CYC - 1, "R4 busy delay single byte");
    readChk(0, 1, "R7 old data while busy");
    doStrobe(2, 3, 8'h11);
    waitFall(m);
    chk(m, PROG_CYC - 4, "R5 programming length single byte");
    applyCommit();
    readChk(0, 1, "R7 new data after busy falls");
    repeat (LOAD_CYC + 4) @(negedge clk);
    chk(int'(busy), 0, "R8 strobe while busy starts no load");
    readChk(2, 3, "R8 strobe while busy not stored");
    sweep("R8 array after ignored strobe");

    finishRun();
  end

endmodule